// File: doc/BRIEF.md
# LPC Host SYNC Phase Monitor

This block watches the SYNC phase of LPC bus cycles from the host side. A single-cycle start strobe opens a cycle. The strobe also captures the transfer direction and the number of bytes the cycle is meant to move. From the clock after the strobe, every LAD nibble is taken as a SYNC nibble. Each nibble is sorted into one of five classes: ready, short wait, long wait, error, or invalid. The monitor counts runs of wait nibbles and runs of invalid nibbles. It then decides whether the cycle finishes normally, finishes with a peripheral error, or has to be aborted.

On a read, each SYNC that ends a byte (ready or error) is followed by two data nibbles. The monitor consumes these before it moves on. On a write, the next byte's SYNC window follows the ready nibble directly. The monitor keeps a running count of completed bytes, so the host can see how much of a multi-byte transfer such as DMA got through before an error ended it.

The result flags hold their value until the next start strobe. The driving of LAD, the START and address phases, and tri-state control are all outside this block.

Top module: `lpc_sync_monitor`

## Requirements
- R1: A start strobe, sampled on a clock edge, clears sync_done, sync_error, abort and bytes_transferred. From the following edge onward, each LAD nibble is treated as a SYNC nibble.
- R2: LAD = 4'b0000 is the ready SYNC. On a write it completes one byte at once. On a read the byte completes on the second of the two data nibbles that follow. When the last byte completes, sync_done is set and abort stays low.
- R3: LAD = 4'b0101 is a short wait. A run of up to 8 consecutive short waits is tolerated. A 9th consecutive short wait sets abort and ends the cycle without sync_done.
- R4: LAD = 4'b0110 is a long wait. Any number of consecutive long waits never sets abort.
- R5: Every nibble other than 0000, 0101, 0110 and 1010 is invalid. The third invalid nibble in a row sets abort. Two invalid nibbles followed by a valid one do not.
- R6: LAD = 4'b1010 is the error SYNC and sets sync_error. On a write, sync_done is set on the same edge. On a read, two more data nibbles are consumed and sync_done is set on the second of them.
- R7: An error SYNC ends a multi-byte cycle: no further byte is counted. bytes_transferred holds the number of bytes that completed before the error. A byte count of zero is treated as one.
- R8: Any nibble that is not a short wait breaks a short-wait run. Any valid nibble breaks an invalid run. This includes a long wait in the middle of a wait sequence.
- R9: A start strobe while a cycle is still in progress abandons that cycle. The strobe wins over the nibble sampled on the same edge, and the new cycle begins from cleared state.
- R10: Outside a cycle (after done or abort, before the next start), LAD nibbles have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-cycle strobe that opens a new SYNC phase |
| is_read | input | 1 | Direction captured at start: 1 read, 0 write |
| byte_cnt | input | BYTE_W | Bytes in the cycle, captured at start |
| lad | input | 4 | LAD nibble sampled each clock |
| sync_done | output | 1 | Cycle ended by ready or error SYNC (held) |
| sync_error | output | 1 | Error SYNC seen in this cycle (held) |
| abort | output | 1 | Cycle aborted by wait or invalid limit (held) |
| bytes_transferred | output | BYTE_W | Bytes completed in the current cycle |

## Verification
Two functions can fall in the same cycle. The first is a restart strobe, which can coincide with a nibble that would otherwise extend or finish the running cycle. The bench provokes this by raising the strobe while a short wait sits on LAD. It judges the outcome by whether the following cycle counts bytes from zero and ends cleanly. The second is an error SYNC that lands partway through a multi-byte read, with the error-induced data nibbles overlapping the point where a byte would normally be counted. The bench judges this by checking that the count freezes at the bytes completed before the error, and that done appears only after the second trailing nibble.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    localparam logic [3:0] NIB_READY = 4'b0000;
    localparam logic [3:0] NIB_SHORT = 4'b0101;
    localparam logic [3:0] NIB_LONG  = 4'b0110;
    localparam logic [3:0] NIB_ERROR = 4'b1010;

    typedef enum logic [2:0] {
        SC_READY,
        SC_SHORT,
        SC_LONG,
        SC_ERROR,
        SC_INVALID
    } sync_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA_HI,
        ST_DATA_LO
    } mon_state_e;

    typedef struct packed {
        logic done;
        logic error;
        logic abort;
    } mon_flags_t;

    function automatic sync_class_e classify_nibble(input logic [3:0] nib);
        sync_class_e c;
        case (nib)
            NIB_READY: c = SC_READY;
            NIB_SHORT: c = SC_SHORT;
            NIB_LONG:  c = SC_LONG;
            NIB_ERROR: c = SC_ERROR;
            default:   c = SC_INVALID;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
    import lpc_sync_pkg::*;
(
    input  logic [3:0]  lad,
    output sync_class_e cls
);
    always_comb begin
        cls = classify_nibble(lad);
    end
endmodule

// File: rtl/lpc_wait_guard.sv
module lpc_wait_guard
    import lpc_sync_pkg::*;
#(
    parameter int SHORT_MAX = 8,
    parameter int INV_LIMIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        active,
    input  sync_class_e cls,
    output logic        abort_req
);
    localparam int SW = $clog2(SHORT_MAX + 1);
    localparam int IW = $clog2(INV_LIMIT + 1);
    localparam logic [SW-1:0] SHORT_CAP = SW'(SHORT_MAX);
    localparam logic [IW-1:0] INV_LAST  = IW'(INV_LIMIT - 1);

    logic [SW-1:0] short_cnt;
    logic [IW-1:0] inv_cnt;
    logic          short_over;
    logic          inv_over;

    always_comb begin
        short_over = (cls == SC_SHORT)   && (short_cnt == SHORT_CAP);
        inv_over   = (cls == SC_INVALID) && (inv_cnt == INV_LAST);
        abort_req  = active && (short_over || inv_over);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || abort_req) begin
            short_cnt <= '0;
            inv_cnt   <= '0;
        end else if (active) begin
            short_cnt <= (cls == SC_SHORT)   ? short_cnt + 1'b1 : '0;
            inv_cnt   <= (cls == SC_INVALID) ? inv_cnt + 1'b1   : '0;
        end
    end

    p_short_cap_r3: assert property (@(posedge clk) disable iff (rst)
        short_cnt <= SHORT_CAP);

    p_inv_cap_r5: assert property (@(posedge clk) disable iff (rst)
        inv_cnt <= INV_LAST);

    p_long_breaks_run_r8: assert property (@(posedge clk) disable iff (rst)
        (active && !clear && cls == SC_LONG) |=> (short_cnt == '0 && inv_cnt == '0));

endmodule

// File: rtl/lpc_byte_tracker.sv
module lpc_byte_tracker #(
    parameter int BYTE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_cnt,
    input  logic              step,
    output logic              last,
    output logic [BYTE_W-1:0] xfer
);
    logic [BYTE_W-1:0] left;

    always_comb begin
        last = (left == BYTE_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            xfer <= '0;
        end else if (load) begin
            left <= (load_cnt == '0) ? BYTE_W'(1) : load_cnt;
            xfer <= '0;
        end else if (step) begin
            left <= left - 1'b1;
            xfer <= xfer + 1'b1;
        end
    end

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |-> (left != '0));

endmodule

// File: rtl/lpc_sync_monitor.sv
module lpc_sync_monitor
    import lpc_sync_pkg::*;
#(
    parameter int BYTE_W    = 3,
    parameter int SHORT_MAX = 8,
    parameter int INV_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_start,
    input  logic              is_read,
    input  logic [BYTE_W-1:0] byte_cnt,
    input  logic [3:0]        lad,
    output logic              sync_done,
    output logic              sync_error,
    output logic              abort,
    output logic [BYTE_W-1:0] bytes_transferred
);
    mon_state_e  state;
    mon_flags_t  flags;
    sync_class_e cls;
    logic        rd_q;
    logic        err_pend;
    logic        in_sync;
    logic        abort_req;
    logic        step;
    logic        last;

    lpc_sync_decode u_decode (
        .lad (lad),
        .cls (cls)
    );

    lpc_wait_guard #(
        .SHORT_MAX (SHORT_MAX),
        .INV_LIMIT (INV_LIMIT)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .clear     (cyc_start),
        .active    (in_sync),
        .cls       (cls),
        .abort_req (abort_req)
    );

    lpc_byte_tracker #(
        .BYTE_W (BYTE_W)
    ) u_bytes (
        .clk      (clk),
        .rst      (rst),
        .load     (cyc_start),
        .load_cnt (byte_cnt),
        .step     (step),
        .last     (last),
        .xfer     (bytes_transferred)
    );

    always_comb begin
        in_sync = (state == ST_SYNC) && !cyc_start;
        step    = !cyc_start &&
                  (((state == ST_SYNC) && (cls == SC_READY) && !rd_q) ||
                   ((state == ST_DATA_LO) && !err_pend));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            flags    <= '0;
            rd_q     <= 1'b0;
            err_pend <= 1'b0;
        end else if (cyc_start) begin
            state    <= ST_SYNC;
            flags    <= '0;
            rd_q     <= is_read;
            err_pend <= 1'b0;
        end else begin
            case (state)
                ST_SYNC: begin
                    if (abort_req) begin
                        flags.abort <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (cls == SC_READY) begin
                        if (rd_q) begin
                            state <= ST_DATA_HI;
                        end else if (last) begin
                            flags.done <= 1'b1;
                            state      <= ST_IDLE;
                        end
                    end else if (cls == SC_ERROR) begin
                        flags.error <= 1'b1;
                        if (rd_q) begin
                            err_pend <= 1'b1;
                            state    <= ST_DATA_HI;
                        end else begin
                            flags.done <= 1'b1;
                            state      <= ST_IDLE;
                        end
                    end
                end
                ST_DATA_HI: state <= ST_DATA_LO;
                ST_DATA_LO: begin
                    if (err_pend || last) begin
                        flags.done <= 1'b1;
                        state      <= ST_IDLE;
                    end else begin
                        state <= ST_SYNC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sync_done  = flags.done;
    assign sync_error = flags.error;
    assign abort      = flags.abort;

    p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
        cyc_start |=> (!sync_done && !sync_error && !abort && bytes_transferred == '0));

    p_done_abort_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(sync_done && abort));

    p_long_never_aborts_r4: assert property (@(posedge clk) disable iff (rst)
        (in_sync && cls == SC_LONG) |=> !abort);

    p_error_freezes_count_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_error && !cyc_start) |=> $stable(bytes_transferred));

    p_idle_ignores_lad_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !cyc_start) |=>
            ($stable(sync_done) && $stable(sync_error) && $stable(abort) &&
             $stable(bytes_transferred)));

endmodule

// File: tb/sim_lpc_sync_monitor.sv
module sim_lpc_sync_monitor;
    localparam int BYTE_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cyc_start = 1'b0;
    logic              is_read = 1'b0;
    logic [BYTE_W-1:0] byte_cnt = '0;
    logic [3:0]        lad = 4'hF;
    logic              sync_done, sync_error, abort;
    logic [BYTE_W-1:0] bytes_transferred;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    lpc_sync_monitor #(.BYTE_W(BYTE_W)) u0 (
        .clk               (clk),
        .rst               (rst),
        .cyc_start         (cyc_start),
        .is_read           (is_read),
        .byte_cnt          (byte_cnt),
        .lad               (lad),
        .sync_done         (sync_done),
        .sync_error        (sync_error),
        .abort             (abort),
        .bytes_transferred (bytes_transferred)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_all(input string req, input int d, input int e, input int a, input int b);
        check(req, "sync_done", int'(sync_done), d);
        check(req, "sync_error", int'(sync_error), e);
        check(req, "abort", int'(abort), a);
        check(req, "bytes_transferred", int'(bytes_transferred), b);
    endtask

    task automatic start(input logic rd, input int cnt);
        cyc_start = 1'b1;
        is_read   = rd;
        byte_cnt  = BYTE_W'(cnt);
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic nib(input logic [3:0] v);
        lad = v;
        @(negedge clk);
    endtask

    task automatic t_reset_r1;
        expect_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_ready_write_r2;
        start(1'b0, 2);
        expect_all("R1", 0, 0, 0, 0);
        nib(4'h0);
        expect_all("R2", 0, 0, 0, 1);
        nib(4'h0);
        expect_all("R2", 1, 0, 0, 2);
    endtask

    task automatic t_ready_read_r2;
        start(1'b1, 1);
        nib(4'h0);
        expect_all("R2", 0, 0, 0, 0);
        nib(4'h3);
        expect_all("R2", 0, 0, 0, 0);
        nib(4'hC);
        expect_all("R2", 1, 0, 0, 1);
    endtask

    task automatic t_short_limit_r3;
        start(1'b0, 1);
        for (int i = 0; i < 8; i++) nib(4'h5);
        check("R3", "abort after 8 short", int'(abort), 0);
        nib(4'h0);
        expect_all("R3", 1, 0, 0, 1);
        start(1'b0, 1);
        for (int i = 0; i < 9; i++) nib(4'h5);
        expect_all("R3", 0, 0, 1, 0);
    endtask

    task automatic t_long_unbounded_r4;
        start(1'b1, 1);
        for (int i = 0; i < 40; i++) nib(4'h6);
        check("R4", "abort after 40 long", int'(abort), 0);
        nib(4'h0); nib(4'h1); nib(4'h2);
        expect_all("R4", 1, 0, 0, 1);
    endtask

    task automatic t_invalid_r5;
        start(1'b0, 1);
        nib(4'hF); nib(4'h7);
        check("R5", "abort after 2 invalid", int'(abort), 0);
        nib(4'h0);
        expect_all("R5", 1, 0, 0, 1);
        start(1'b0, 1);
        nib(4'h1); nib(4'hB); nib(4'h9);
        expect_all("R5", 0, 0, 1, 0);
    endtask

    task automatic t_error_write_r6;
        start(1'b0, 4);
        nib(4'h0); nib(4'h0);
        nib(4'hA);
        expect_all("R6", 1, 1, 0, 2);
    endtask

    task automatic t_error_read_r7;
        start(1'b1, 3);
        nib(4'h0); nib(4'h4); nib(4'h4);
        check("R7", "count after first byte", int'(bytes_transferred), 1);
        nib(4'hA);
        expect_all("R6", 0, 1, 0, 1);
        nib(4'h8);
        expect_all("R6", 0, 1, 0, 1);
        nib(4'h8);
        expect_all("R7", 1, 1, 0, 1);
        nib(4'h0); nib(4'h0);
        check("R7", "count frozen after error", int'(bytes_transferred), 1);
        start(1'b0, 0);
        nib(4'h0);
        expect_all("R7", 1, 0, 0, 1);
    endtask

    task automatic t_run_breaks_r8;
        start(1'b0, 1);
        for (int i = 0; i < 8; i++) nib(4'h5);
        nib(4'h6);
        for (int i = 0; i < 8; i++) nib(4'h5);
        nib(4'hE); nib(4'hE); nib(4'h5); nib(4'hE); nib(4'hE);
        check("R8", "abort after broken runs", int'(abort), 0);
        nib(4'h0);
        expect_all("R8", 1, 0, 0, 1);
    endtask

    task automatic t_restart_r9;
        start(1'b0, 3);
        nib(4'h0);
        check("R9", "first cycle count", int'(bytes_transferred), 1);
        lad = 4'h5;
        start(1'b1, 2);
        expect_all("R9", 0, 0, 0, 0);
        nib(4'h0); nib(4'h2); nib(4'h2);
        expect_all("R9", 0, 0, 0, 1);
        nib(4'h0); nib(4'h2); nib(4'h2);
        expect_all("R9", 1, 0, 0, 2);
    endtask

    task automatic t_idle_ignore_r10;
        start(1'b0, 1);
        nib(4'h0);
        nib(4'hF); nib(4'hF); nib(4'hF); nib(4'hA); nib(4'h0);
        expect_all("R10", 1, 0, 0, 1);
        start(1'b0, 1);
        nib(4'hF); nib(4'hF); nib(4'hF);
        nib(4'h0); nib(4'hA);
        expect_all("R10", 0, 0, 1, 0);
    endtask

    task automatic finish_run;
        if (!reported) begin
            reported = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r1();
        t_ready_write_r2();
        t_ready_read_r2();
        t_short_limit_r3();
        t_long_unbounded_r4();
        t_invalid_r5();
        t_error_write_r6();
        t_error_read_r7();
        t_run_breaks_r8();
        t_restart_r9();
        t_idle_ignore_r10();
        finish_run();
    end
endmodule